// File: doc/BRIEF.md
# Power Mode Clock Gating Controller

This block decides which clocks of a small system-on-chip run in each of three power modes: run, wait and stop. The core asks for wait or stop with a one-cycle request. The controller then removes the clock enable of the core and memory. In stop it also removes the clock enables of the peripherals. The exception is any peripheral whose keep-alive bit was set when stop was entered.

Wake-up rules return the controller to run. In wait, any peripheral interrupt, the low-voltage interrupt or a debug-entry request is enough. In stop, only three things wake it: an interrupt from a peripheral that kept its clock, the low-voltage interrupt, or a debug-entry request. An asynchronous reset forces run from any mode. A two-bit status output reports the current mode.

Top module: `pmode_clk_ctrl`

## Requirements
- R1: While `rstN` is low, the controller is in run, with `coreMemClkEn`=1, every `periphClkEn` bit at 1 and `modeStatus`=00. This takes effect without waiting for a clock edge.
- R2: In run, `coreMemClkEn` and every `periphClkEn` bit are 1.
- R3: In run, with `reqWait`=1, `reqStop`=0 and no wake source asserted, the next edge moves the controller to wait. Wait has `coreMemClkEn`=0 and every `periphClkEn` bit at 1.
- R4: In run, with `reqStop`=1 and no stop wake source asserted, the next edge moves the controller to stop. Stop has `coreMemClkEn`=0, and `periphClkEn` equals the `stopKeep` value sampled on that edge.
- R5: When `reqWait` and `reqStop` are both 1 in run, stop is taken.
- R6: In wait, any bit of `periphIrq`, `lowVoltIrq` or `dbgEntry` returns the controller to run on the next edge.
- R7: In stop, three sources return the controller to run on the next edge: a `periphIrq` bit whose held keep-alive bit is 1, `lowVoltIrq`, or `dbgEntry`.
- R8: In stop, a `periphIrq` bit whose held keep-alive bit is 0 does not wake the controller.
- R9: A request is ignored, and the controller stays in run, when a wake condition is already asserted in the same cycle. For stop, that condition is judged with the live `stopKeep`.
- R10: While in stop, changes on `stopKeep` change neither `periphClkEn` nor which interrupts wake the controller.
- R11: `modeStatus` is 00 in run, 01 in wait and 10 in stop, and never 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqWait | input | 1 | Core request to enter wait |
| reqStop | input | 1 | Core request to enter stop |
| stopKeep | input | PERIPH_COUNT | Per-peripheral keep-clock-in-stop bits |
| periphIrq | input | PERIPH_COUNT | Peripheral interrupt lines |
| lowVoltIrq | input | 1 | Low-voltage interrupt |
| dbgEntry | input | 1 | Debug-mode entry request |
| coreMemClkEn | output | 1 | Clock enable for core and memory |
| periphClkEn | output | PERIPH_COUNT | Clock enable per peripheral |
| modeStatus | output | 2 | Current mode: 00 run, 01 wait, 10 stop |

## Verification
Directed sequences enter stop with several keep masks. They then offer interrupts on kept lanes, on unkept lanes, and on lanes set only in the later live mask. This separates a design that holds the mask from one that reads it live, and separates stop-wake rules from wait-wake rules. Requests that coincide with wake sources show whether entry is blocked. Simultaneous wait and stop requests show the priority. A long stretch of random requests, masks and interrupts is compared cycle by cycle against a behavioural model. An asynchronous reset asserted in stop shows that the enables return at once.

// File: rtl/pmode_pkg.sv
package pmode_pkg;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'b00,
    MODE_WAIT = 2'b01,
    MODE_STOP = 2'b10
  } pmode_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic loadMask;   // capture keep mask on this edge (stop entry)
    logic gateCore;   // core and memory clock off
    logic gatePeriph; // peripherals follow the held mask
  } pmodeStrobe_t;

endpackage

// File: rtl/pmode_dp.sv
module pmode_dp
  import pmode_pkg::*;
#(
  parameter int PERIPH_COUNT = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  pmodeStrobe_t            strobes,
  input  logic [PERIPH_COUNT-1:0] stopKeep,
  input  logic [PERIPH_COUNT-1:0] periphIrq,
  input  logic                    lowVoltIrq,
  input  logic                    dbgEntry,
  output logic                    wakeAny,
  output logic                    wakeStopLive,
  output logic                    wakeStopHeld,
  output logic                    coreMemClkEn,
  output logic [PERIPH_COUNT-1:0] periphClkEn
);

  logic [PERIPH_COUNT-1:0] heldMask;
  logic                    sysWake;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 heldMask <= '0;
    else if (strobes.loadMask) heldMask <= stopKeep;
  end

  assign sysWake      = lowVoltIrq | dbgEntry;
  assign wakeAny      = (|periphIrq) | sysWake;
  assign wakeStopLive = (|(periphIrq & stopKeep)) | sysWake;
  assign wakeStopHeld = (|(periphIrq & heldMask)) | sysWake;

  assign coreMemClkEn = !strobes.gateCore;

  for (genvar i = 0; i < PERIPH_COUNT; i++) begin : g_lane
    assign periphClkEn[i] = !strobes.gatePeriph || heldMask[i];
  end

  // R4
  stop_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadMask |=> (periphClkEn == $past(stopKeep)) && !coreMemClkEn);

  // R10
  held_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.gatePeriph |=> $stable(heldMask));

endmodule

// File: rtl/pmode_ctl.sv
module pmode_ctl
  import pmode_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqWait,
  input  logic         reqStop,
  input  logic         wakeAny,
  input  logic         wakeStopLive,
  input  logic         wakeStopHeld,
  output pmodeStrobe_t strobes,
  output logic [1:0]   modeStatus
);

  pmode_e mode, modeNext;

  always_comb begin
    modeNext = mode;
    unique case (mode)
      MODE_RUN: begin
        if (reqStop) begin
          if (!wakeStopLive) modeNext = MODE_STOP;
        end else if (reqWait && !wakeAny) begin
          modeNext = MODE_WAIT;
        end
      end
      MODE_WAIT: if (wakeAny)      modeNext = MODE_RUN;
      MODE_STOP: if (wakeStopHeld) modeNext = MODE_RUN;
      default:                     modeNext = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) mode <= MODE_RUN;
    else       mode <= modeNext;
  end

  assign strobes.loadMask   = (mode == MODE_RUN) && (modeNext == MODE_STOP);
  assign strobes.gateCore   = (mode != MODE_RUN);
  assign strobes.gatePeriph = (mode == MODE_STOP);
  assign modeStatus         = mode;

  // R6
  wait_wake_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeStatus == 2'b01 && wakeAny) |=> modeStatus == 2'b00);

  // R8
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeStatus == 2'b10 && !wakeStopHeld) |=> modeStatus == 2'b10);

  // R9
  stop_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeStatus == 2'b00 && reqStop && wakeStopLive) |=> modeStatus == 2'b00);

  // R9
  wait_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeStatus == 2'b00 && reqWait && wakeAny) |=> modeStatus != 2'b01);

  // R11
  status_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeStatus != 2'b11);

endmodule

// File: rtl/pmode_clk_ctrl.sv
module pmode_clk_ctrl
  import pmode_pkg::*;
#(
  parameter int PERIPH_COUNT = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqWait,
  input  logic                    reqStop,
  input  logic [PERIPH_COUNT-1:0] stopKeep,
  input  logic [PERIPH_COUNT-1:0] periphIrq,
  input  logic                    lowVoltIrq,
  input  logic                    dbgEntry,
  output logic                    coreMemClkEn,
  output logic [PERIPH_COUNT-1:0] periphClkEn,
  output logic [1:0]              modeStatus
);

  pmodeStrobe_t strobes;
  logic wakeAny, wakeStopLive, wakeStopHeld;

  pmode_ctl u_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .reqWait      (reqWait),
    .reqStop      (reqStop),
    .wakeAny      (wakeAny),
    .wakeStopLive (wakeStopLive),
    .wakeStopHeld (wakeStopHeld),
    .strobes      (strobes),
    .modeStatus   (modeStatus)
  );

  pmode_dp #(.PERIPH_COUNT(PERIPH_COUNT)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .stopKeep     (stopKeep),
    .periphIrq    (periphIrq),
    .lowVoltIrq   (lowVoltIrq),
    .dbgEntry     (dbgEntry),
    .wakeAny      (wakeAny),
    .wakeStopLive (wakeStopLive),
    .wakeStopHeld (wakeStopHeld),
    .coreMemClkEn (coreMemClkEn),
    .periphClkEn  (periphClkEn)
  );

endmodule

// File: tb/pmode_clk_ctrl_test.sv
module pmode_clk_ctrl_test;

  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqWait = 1'b0, reqStop = 1'b0, lowVoltIrq = 1'b0, dbgEntry = 1'b0;
  logic [N-1:0] stopKeep = '0, periphIrq = '0;
  logic         coreMemClkEn;
  logic [N-1:0] periphClkEn;
  logic [1:0]   modeStatus;

  int checks = 0, failures = 0;
  bit done = 0;

  // behavioural model: 0 run, 1 wait, 2 stop
  int           mMode = 0;
  logic [N-1:0] mHeld = '0;
  string        lastTag = "R1";

  pmode_clk_ctrl #(.PERIPH_COUNT(N)) uut (
    .clk(clk), .rstN(rstN), .reqWait(reqWait), .reqStop(reqStop),
    .stopKeep(stopKeep), .periphIrq(periphIrq), .lowVoltIrq(lowVoltIrq),
    .dbgEntry(dbgEntry), .coreMemClkEn(coreMemClkEn),
    .periphClkEn(periphClkEn), .modeStatus(modeStatus)
  );

  always #10 clk = ~clk;

  task automatic compare(string tag);
    logic         expCore;
    logic [N-1:0] expPer;
    logic [1:0]   expStat;
    expCore = (mMode == 0);
    expPer  = (mMode == 2) ? mHeld : {N{1'b1}};
    expStat = 2'(mMode);
    checks++;
    if (coreMemClkEn !== expCore || periphClkEn !== expPer || modeStatus !== expStat) begin
      failures++;
      $display("FAIL %s: core=%b per=%h stat=%b expected core=%b per=%h stat=%b",
               tag, coreMemClkEn, periphClkEn, modeStatus, expCore, expPer, expStat);
    end
  endtask

  task automatic step(string tag, logic rw, logic rs, logic [N-1:0] keep,
                      logic [N-1:0] irq, logic lv, logic dbg);
    bit anyW, stopLiveW, stopHeldW;
    @(negedge clk);
    compare(lastTag);
    reqWait = rw; reqStop = rs; stopKeep = keep; periphIrq = irq;
    lowVoltIrq = lv; dbgEntry = dbg;
    anyW      = (irq != 0) || lv || dbg;
    stopLiveW = ((irq & keep) != 0) || lv || dbg;
    stopHeldW = ((irq & mHeld) != 0) || lv || dbg;
    if (mMode == 0) begin
      if (rs) begin
        if (!stopLiveW) begin mMode = 2; mHeld = keep; end
      end else if (rw && !anyW) mMode = 1;
    end else if (mMode == 1) begin
      if (anyW) mMode = 0;
    end else begin
      if (stopHeldW) mMode = 0;
    end
    lastTag = tag;
  endtask

  task automatic idle(string tag, logic [N-1:0] keep);
    step(tag, 1'b0, 1'b0, keep, '0, 1'b0, 1'b0);
  endtask

  initial begin
    #3;
    compare("R1");              // reset state before any edge
    repeat (2) @(negedge clk);
    compare("R1");
    rstN = 1'b1;
    lastTag = "R2";
    idle("R2", '0); idle("R2", 8'hFF);

    // wait entry, stay, wake on a peripheral irq
    step("R3", 1, 0, 8'h00, 8'h00, 0, 0);
    idle("R3", 8'h00);
    step("R6", 0, 0, 8'h00, 8'h08, 0, 0);
    idle("R2", 8'h00);

    // stop with mask 05, live mask changes, masked irqs ignored
    step("R4", 0, 1, 8'h05, 8'h00, 0, 0);
    idle("R10", 8'hF0);
    step("R8", 0, 0, 8'hF0, 8'h02, 0, 0);
    step("R10", 0, 0, 8'hF0, 8'h10, 0, 0);
    step("R7", 0, 0, 8'hF0, 8'h04, 0, 0);
    idle("R2", 8'h00);

    // stop wakes on low-voltage and on debug
    step("R4", 0, 1, 8'h01, 8'h00, 0, 0);
    step("R7", 0, 0, 8'h00, 8'h00, 1, 0);
    step("R4", 0, 1, 8'h00, 8'h00, 0, 0);
    step("R8", 0, 0, 8'h00, 8'hFF, 0, 0);
    step("R7", 0, 0, 8'h00, 8'h00, 0, 1);
    idle("R2", 8'h00);

    // both requests: stop wins, then wake on its kept lane
    step("R5", 1, 1, 8'h80, 8'h00, 0, 0);
    idle("R5", 8'h00);
    step("R7", 0, 0, 8'h00, 8'h80, 0, 0);

    // entry blocked by an active wake source
    step("R9", 1, 0, 8'h00, 8'h01, 0, 0);
    step("R9", 0, 1, 8'h02, 8'h02, 0, 0);
    step("R9", 1, 0, 8'h00, 8'h00, 0, 1);
    step("R9", 0, 1, 8'h00, 8'h00, 1, 0);
    step("R9", 0, 1, 8'h02, 8'h01, 0, 0);   // unkept irq: stop entered
    step("R7", 0, 0, 8'h00, 8'h00, 1, 0);

    // wait wake on debug and on low voltage
    step("R3", 1, 0, 8'h00, 8'h00, 0, 0);
    step("R6", 0, 0, 8'h00, 8'h00, 0, 1);
    step("R3", 1, 0, 8'h00, 8'h00, 0, 0);
    step("R6", 0, 0, 8'h00, 8'h00, 1, 0);

    // random mix against the model
    for (int k = 0; k < 400; k++) begin
      logic [N-1:0] rIrq;
      rIrq = ($urandom_range(0, 3) == 0) ? N'($urandom) : '0;
      step("R11", ($urandom_range(0, 3) == 0), ($urandom_range(0, 4) == 0),
           N'($urandom), rIrq, ($urandom_range(0, 15) == 0),
           ($urandom_range(0, 15) == 0));
    end

    // async reset while in stop
    step("R4", 0, 1, 8'h00, 8'h00, 0, 0);
    idle("R4", 8'h00);
    @(negedge clk);
    compare(lastTag);
    #3 rstN = 1'b0;
    #1;
    mMode = 0; mHeld = '0;
    compare("R1");
    @(negedge clk);
    rstN = 1'b1;
    lastTag = "R1";
    idle("R2", 8'h00);
    idle("R2", 8'h00);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 50000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule